// File: doc/BRIEF.md
# SPI Frame CRC Guard

This block protects the word-oriented serial frames of a converter-style peripheral with 16-bit CRCs. On the input side it computes a CRC over the first word of each frame, the command, and compares it with the CRC word that follows. For a register-write command it also runs a second check over the data words that come after the command CRC word. A command is released to the decoder through a one-cycle execute pulse only when every required check has matched.

On the output side it keeps a running CRC over every word shifted out in the frame and presents it, left-aligned in a full word, so that the shifter can append it as the last output word. A mismatch in any input check raises a fault flag at the end of the frame. The flag stays up for the whole of the next frame, where the response multiplexer uses it to send the null-command response and show the fault in the status word. It then drops by itself unless that frame also failed.

The shift register, the command decoder, the register file and the converter datapath are outside this block. They connect through word-valid strobes, the write-command and data-count hints, and the execute pulse.

Top module: `spi_crc_guard`

## Requirements
- R1: While `cs_n` is high, and therefore at the start of every frame, the input CRC and the output CRC are both held at the seed 0xFFFF.
- R2: `poly_sel` = 0 selects polynomial 0x1021 and `poly_sel` = 1 selects 0x8005 for all three CRCs. The value is taken in the first cycle with `cs_n` low and holds for the whole frame, even if `poly_sel` changes later in the frame.
- R3: Each CRC processes every bit of a covered word, padding included, MSB first, with no reflection and no final XOR. In a received CRC word the CRC sits in the upper 16 bits, and the lower `W`-16 bits are ignored.
- R4: For a non-write command (`cmd_is_write` = 0 with word 0), `exec_en` pulses high for exactly one cycle, in the cycle after word 1 is accepted, if word 1 carries the CRC of word 0.
- R5: For a write command, `wr_words` (sampled with word 0) data words follow the command CRC word. Their CRC is computed from a fresh seed and checked against the next word. `exec_en` pulses after that word only if both checks matched, and never after the command CRC word.
- R6: When either check in a frame mismatches, `exec_en` stays low for the rest of that frame.
- R7: At each rising edge of `cs_n`, `crc_fault` takes whether a mismatch occurred in the frame just ended. It changes at no other time, so it stays high through the following frame and clears at that frame's end unless that frame also failed.
- R8: Input words after the last required CRC word have no effect. A frame that ends before its last required CRC word produces no `exec_en` and no fault.
- R9: `tx_crc_word` carries, in its upper 16 bits, the CRC of all `out_valid` words since `cs_n` fell, with zeros below. It is current in the cycle after the last word is accepted.
- R10: After reset `exec_en` and `crc_fault` are low and `tx_crc_word` holds the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Frame select, active low |
| poly_sel | input | 1 | Polynomial select: 0 = 0x1021, 1 = 0x8005 |
| in_valid | input | 1 | Input word strobe |
| in_word | input | W | Received word |
| cmd_is_write | input | 1 | Decoder hint, valid with word 0: register-write command |
| wr_words | input | NW | Decoder hint, valid with word 0: number of data words |
| out_valid | input | 1 | Output word strobe |
| out_word | input | W | Word being shifted out |
| exec_en | output | 1 | One-cycle execute permission |
| crc_fault | output | 1 | CRC fault of the previous frame |
| tx_crc_word | output | W | Output CRC, left-aligned, zero-padded |

## Verification
The bench aims at the cases where a check sits in the wrong place. A guard that gives execute permission after the command CRC on a write would pulse one word too early. One that reuses the command CRC as the data seed would reject good data. One that lets trailing words through would pulse a second time. It changes `poly_sel` in the middle of a frame, which catches a design that does not hold the polynomial for the frame. It puts nonzero padding in the received CRC words, which catches a design that compares the full word. It runs two failed frames in a row and then a good one, which catches a fault flag that clears too early or never re-arms. It also ends a write frame short, where a design that counts a missing CRC as an error would raise a false fault.

// File: rtl/spi_crc_guard.sv
module spi_crc_guard #(
  parameter int W  = 24,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          poly_sel,
  input  logic          in_valid,
  input  logic [W-1:0]  in_word,
  input  logic          cmd_is_write,
  input  logic [NW-1:0] wr_words,
  input  logic          out_valid,
  input  logic [W-1:0]  out_word,
  output logic          exec_en,
  output logic          crc_fault,
  output logic [W-1:0]  tx_crc_word
);
  localparam logic [15:0] SEED   = 16'hFFFF;
  localparam logic [15:0] POLY_A = 16'h1021;
  localparam logic [15:0] POLY_B = 16'h8005;
  localparam int          PAD    = W - 16;

  typedef enum logic [2:0] {PH_CMD, PH_CCRC, PH_DATA, PH_DCRC, PH_DONE} phase_t;

  phase_t        phase;
  logic          cs_q, err_q, wr_q;
  logic [15:0]   in_crc, out_crc, poly_q;
  logic [NW-1:0] left;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [W-1:0] d,
                                           input logic [15:0] p);
    logic [15:0] r;
    r = c;
    for (int i = W - 1; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? p : 16'h0000);
    return r;
  endfunction

  wire [15:0] poly_now  = cs_q ? (poly_sel ? POLY_B : POLY_A) : poly_q;
  wire        crc_match = (in_word[W-1 -: 16] == in_crc);
  wire        frame_end = cs_n & ~cs_q;

  assign tx_crc_word = W'(out_crc) << PAD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      err_q     <= 1'b0;
      wr_q      <= 1'b0;
      in_crc    <= SEED;
      out_crc   <= SEED;
      poly_q    <= POLY_A;
      left      <= '0;
      phase     <= PH_CMD;
      exec_en   <= 1'b0;
      crc_fault <= 1'b0;
    end else begin
      cs_q    <= cs_n;
      exec_en <= 1'b0;
      if (cs_n) begin
        in_crc  <= SEED;
        out_crc <= SEED;
        phase   <= PH_CMD;
        err_q   <= 1'b0;
        if (!cs_q) crc_fault <= err_q;
      end else begin
        if (cs_q) poly_q <= poly_now;
        if (out_valid) out_crc <= crc_step(out_crc, out_word, poly_now);
        if (in_valid) begin
          case (phase)
            PH_CMD: begin
              in_crc <= crc_step(in_crc, in_word, poly_now);
              wr_q   <= cmd_is_write;
              left   <= wr_words;
              phase  <= PH_CCRC;
            end
            PH_CCRC: begin
              in_crc <= SEED;
              if (!crc_match) err_q <= 1'b1;
              if (!wr_q) begin
                exec_en <= crc_match;
                phase   <= PH_DONE;
              end else begin
                phase <= (left == '0) ? PH_DCRC : PH_DATA;
              end
            end
            PH_DATA: begin
              in_crc <= crc_step(in_crc, in_word, poly_now);
              left   <= left - 1'b1;
              if (left == NW'(1)) phase <= PH_DCRC;
            end
            PH_DCRC: begin
              if (!crc_match) err_q <= 1'b1;
              exec_en <= crc_match & ~err_q;
              phase   <= PH_DONE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_EXEC_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> !exec_en);                                                   // R4
  AST_EXEC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |-> !err_q);                                                     // R6
  AST_EXEC_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |-> !cs_q);                                                      // R8
  AST_FAULT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(crc_fault));                                      // R7
  AST_SEED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (tx_crc_word[W-1 -: 16] == SEED && in_crc == SEED));            // R1
  AST_POLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cs_q) |=> $stable(poly_q));                                   // R2
endmodule

// File: tb/test_spi_crc_guard.sv
`timescale 1ns/1ps
module test_spi_crc_guard;
  localparam int W = 24;
  localparam int NW = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, poly_sel = 1'b0;
  logic in_valid = 1'b0, cmd_is_write = 1'b0, out_valid = 1'b0;
  logic [W-1:0] in_word = '0, out_word = '0;
  logic [NW-1:0] wr_words = '0;
  logic exec_en, crc_fault;
  logic [W-1:0] tx_crc_word;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  spi_crc_guard #(.W(W), .NW(NW)) i_spi_crc_guard (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .poly_sel(poly_sel),
    .in_valid(in_valid), .in_word(in_word), .cmd_is_write(cmd_is_write),
    .wr_words(wr_words), .out_valid(out_valid), .out_word(out_word),
    .exec_en(exec_en), .crc_fault(crc_fault), .tx_crc_word(tx_crc_word));

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [W-1:0] d,
                                          input logic sel);
    logic [15:0] p, r;
    p = sel ? 16'h8005 : 16'h1021;
    r = c;
    for (int k = W - 1; k >= 0; k--) begin
      if (r[15] != d[k]) r = {r[14:0], 1'b0} ^ p;
      else               r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame_begin(input logic sel);
    @(negedge clk); poly_sel = sel; cs_n = 1'b0;
  endtask

  task automatic frame_end;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic [W-1:0] w, input logic wr, input int n);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; cmd_is_write = wr; wr_words = NW'(n);
    @(negedge clk);
    in_valid = 1'b0; cmd_is_write = 1'b0;
  endtask

  task automatic t_reset;
    chk(exec_en == 1'b0, "R10 exec", W'(exec_en), 0);
    chk(crc_fault == 1'b0, "R10 fault", W'(crc_fault), 0);
    chk(tx_crc_word == 24'hFFFF00, "R10 tx", tx_crc_word, 24'hFFFF00);
  endtask

  task automatic t_read(input logic sel, input logic [W-1:0] cmd);
    logic [15:0] c;
    c = ref_crc(16'hFFFF, cmd, sel);
    frame_begin(sel);
    put(cmd, 1'b0, 0);
    chk(exec_en == 1'b0, "R4 no exec on cmd", W'(exec_en), 0);
    put({c, 8'h5A}, 1'b0, 0);
    chk(exec_en == 1'b1, "R4 R3 exec after crc", W'(exec_en), 1);
    @(negedge clk);
    chk(exec_en == 1'b0, "R4 single pulse", W'(exec_en), 0);
    put({c, 8'h00}, 1'b0, 0);
    chk(exec_en == 1'b0, "R8 trailing word ignored", W'(exec_en), 0);
    frame_end();
    chk(crc_fault == 1'b0, "R7 no fault", W'(crc_fault), 0);
  endtask

  task automatic t_bad_then_good;
    logic [W-1:0] cmd;
    logic [15:0] c;
    cmd = 24'h0600A0;
    c = ref_crc(16'hFFFF, cmd, 1'b0);
    frame_begin(1'b0);
    put(cmd, 1'b0, 0);
    put({c ^ 16'h0001, 8'h00}, 1'b0, 0);
    chk(exec_en == 1'b0, "R6 bad cmd crc", W'(exec_en), 0);
    frame_end();
    chk(crc_fault == 1'b1, "R7 fault set", W'(crc_fault), 1);
    frame_begin(1'b0);
    put(cmd, 1'b0, 0);
    put(24'h000000, 1'b0, 0);
    chk(crc_fault == 1'b1, "R7 fault held in next frame", W'(crc_fault), 1);
    frame_end();
    chk(crc_fault == 1'b1, "R7 second error keeps fault", W'(crc_fault), 1);
    t_read(1'b0, 24'h010203);
  endtask

  task automatic t_write(input logic sel, input int n, input logic corrupt);
    logic [W-1:0] cmd, d;
    logic [15:0] cc, dc;
    cmd = 24'h4C0200 | W'(n);
    cc = ref_crc(16'hFFFF, cmd, sel);
    dc = 16'hFFFF;
    frame_begin(sel);
    put(cmd, 1'b1, n);
    put({cc, 8'hC3}, 1'b0, 0);
    chk(exec_en == 1'b0, "R5 no exec after cmd crc", W'(exec_en), 0);
    for (int k = 0; k < n; k++) begin
      d = 24'h123400 + W'(k * 24'h010101);
      dc = ref_crc(dc, d, sel);
      put(d, 1'b0, 0);
    end
    put({corrupt ? ~dc : dc, 8'h00}, 1'b0, 0);
    chk(exec_en == !corrupt, corrupt ? "R6 bad data crc" : "R5 write exec",
        W'(exec_en), W'(!corrupt));
    frame_end();
    chk(crc_fault == corrupt, "R7 write fault", W'(crc_fault), W'(corrupt));
  endtask

  task automatic t_short_write;
    logic [W-1:0] cmd;
    cmd = 24'h4C0102;
    frame_begin(1'b1);
    put(cmd, 1'b1, 2);
    put({ref_crc(16'hFFFF, cmd, 1'b1), 8'h00}, 1'b0, 0);
    put(24'hABCDEF, 1'b0, 0);
    frame_end();
    chk(exec_en == 1'b0, "R8 short frame no exec", W'(exec_en), 0);
    chk(crc_fault == 1'b0, "R8 short frame no fault", W'(crc_fault), 0);
  endtask

  task automatic t_poly_latched;
    logic [W-1:0] cmd;
    logic [15:0] c;
    cmd = 24'h7E0011;
    c = ref_crc(16'hFFFF, cmd, 1'b1);
    frame_begin(1'b1);
    @(negedge clk); poly_sel = 1'b0;
    put(cmd, 1'b0, 0);
    put({c, 8'h00}, 1'b0, 0);
    chk(exec_en == 1'b1, "R2 polynomial held for frame", W'(exec_en), 1);
    frame_end();
  endtask

  task automatic t_out_crc(input logic sel);
    logic [15:0] c;
    logic [W-1:0] w;
    c = 16'hFFFF;
    frame_begin(sel);
    @(negedge clk);
    chk(tx_crc_word == 24'hFFFF00, "R1 seed at frame start", tx_crc_word, 24'hFFFF00);
    for (int k = 0; k < 4; k++) begin
      w = 24'h800001 ^ W'(k * 24'h135791);
      c = ref_crc(c, w, sel);
      out_valid = 1'b1; out_word = w;
      @(negedge clk);
    end
    out_valid = 1'b0;
    chk(tx_crc_word == {c, 8'h00}, "R9 output crc", tx_crc_word, {c, 8'h00});
    frame_end();
    chk(tx_crc_word == 24'hFFFF00, "R1 reseed after frame", tx_crc_word, 24'hFFFF00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read(1'b0, 24'h112233);
    t_read(1'b1, 24'h000000);
    t_bad_then_good();
    t_write(1'b0, 3, 1'b0);
    t_write(1'b1, 1, 1'b0);
    t_write(1'b0, 2, 1'b1);
    t_write(1'b1, 0, 1'b0);
    t_short_write();
    t_poly_latched();
    t_out_crc(1'b0);
    t_out_crc(1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule